// File: doc/BRIEF.md
# Tiled Surface Byte-Offset Generator

This block turns integer texel coordinates into a byte offset inside a surface whose memory layout is linear, X-tiled or Y-tiled. A request carries one, two or three coordinates and a dimension count. The surface is described by a set of parameter inputs: a 2-D placement offset, log2 tile extents, strides, bytes per texel and two swizzle shift amounts. One datapath serves both tiled layouts. A Y tile is handled as a stack of narrow sub-columns, and its tile width parameter is the width of one sub-column. A third coordinate, a slice or array layer, is split into a minor part that moves the texel sideways and a major part that moves it down.

The block starts work on a one-cycle `start` strobe. It walks a fixed sequence of steps that share a single 32-bit multiplier. It returns the offset together with an in-bounds flag and a one-cycle `done` strobe. A consumer uses the in-bounds flag to suppress the access and return zero. The surface parameter inputs must stay stable from `start` until `done`. All arithmetic wraps modulo 2^32.

Top module: `tiled_addr_gen`

## Requirements
- R1: While `rst` is high and after its release, `done`, `byte_off` and `in_bounds` are 0 until the first request completes.
- R2: For a `start` sampled high on a rising edge while idle, `done` is high for exactly one cycle following the sixth rising edge after that one. `byte_off` and `in_bounds` update with it and hold their values until the next `done`.
- R3: A `start` that arrives while a request is in progress is ignored. It does not change that request's result and does not cause an extra `done`.
- R4: `dims` encoding: 0 or 1 means x only, 2 means x and y, 3 means x, y and z. The working x is `base_x + coord_x`. The working y is `base_y + coord_y` when `dims` is 2 or more, and `base_y` alone otherwise.
- R5: When `dims` is 3, the z minor part `coord_z mod 2^tile_lz` times `slice_dx` is added to the working x. The z major part `coord_z >> tile_lz` times `slice_dy` is added to the working y. When `dims` is below 3, z has no effect.
- R6: With `tiled` = 0, `byte_off = (y * row_pitch + x) * bytes_pp` on the working coordinates, and no swizzle is applied.
- R7: With `tiled` = 1, the minor and major indices of x and y are split using `tile_lx` and `tile_ly`. The in-row index is `(((major_x << tile_ly) + minor_y) << tile_lx) + minor_x`. The row term is `major_y << tile_ly`. `byte_off = (index + row * row_pitch) * bytes_pp`, followed by the swizzle of R8.
- R8: In tiled mode, the bit `((off >> swz_sa) ^ (off >> swz_sb))[6]` is XORed into bit 6 of the offset. A shift amount of 31 or more, 0xFF included, contributes a zero bit, so one such value gives single-bit swizzling and two disable it.
- R9: `in_bounds` is 1 only when every used coordinate, compared unsigned, is strictly below its `size_*` input. The used coordinates are given by `dims` as in R4.
- R10: Every addition and multiplication wraps modulo 2^32.
- R11: The tile shift inputs `tile_lx`, `tile_ly` and `tile_lz` take any value from 0 to 31, including 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when idle |
| dims | input | 2 | Number of coordinates used (0/1, 2, 3) |
| tiled | input | 1 | 1 selects tiled layout, 0 linear |
| coord_x | input | 32 | Texel x coordinate |
| coord_y | input | 32 | Texel y coordinate |
| coord_z | input | 32 | Slice or layer coordinate |
| base_x | input | 32 | Surface placement x offset |
| base_y | input | 32 | Surface placement y offset |
| size_x | input | 32 | Surface width limit |
| size_y | input | 32 | Surface height limit |
| size_z | input | 32 | Surface depth or layer limit |
| tile_lx | input | 5 | log2 tile width in texels |
| tile_ly | input | 5 | log2 tile height in rows |
| tile_lz | input | 5 | log2 slices per slice row |
| bytes_pp | input | 32 | Bytes per texel |
| row_pitch | input | 32 | Row stride in texels |
| slice_dx | input | 32 | Horizontal step per minor slice |
| slice_dy | input | 32 | Vertical step per major slice |
| swz_sa | input | 8 | First swizzle shift amount |
| swz_sb | input | 8 | Second swizzle shift amount |
| done | output | 1 | Result strobe, one cycle |
| byte_off | output | 32 | Computed byte offset |
| in_bounds | output | 1 | All used coordinates inside the surface |

## Verification
All results of a request, offset and in-bounds flag alike, become visible after the sixth rising edge that follows the edge sampling `start`. Stimulus is driven and outputs are read on falling edges. For every request the bench confirms that `done` is still low after the fifth edge, high with the expected values after the sixth, and low again one cycle later with the offset unchanged. Expected offsets come from a division-and-modulo formulation of the layout, swept over all dimension counts, linear and tiled configurations and coordinates that straddle the surface limits. Directed cases cover wraparound, the saturating swizzle shifts and a request attempted mid-flight.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZMIN,
    ST_ZMAJ,
    ST_TILE,
    ST_ROW,
    ST_BPP,
    ST_SWZ
  } seq_state_t;
endpackage

// File: rtl/addr_mul.sv
module addr_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod
);
  // low W bits only: the product wraps modulo 2^W
  assign prod = op_a * op_b;
endmodule

// File: rtl/addr_bounds.sv
module addr_bounds #(
  parameter int W     = 32,
  parameter int LANES = 3
) (
  input  logic [LANES*W-1:0] coord_flat,
  input  logic [LANES*W-1:0] size_flat,
  input  logic [1:0]         dims,
  output logic               in_bounds
);
  logic [LANES-1:0] lane_ok;
  logic [2:0]       used;

  assign used = (dims == 2'd0) ? 3'd1 : {1'b0, dims};

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      logic [W-1:0] c;
      logic [W-1:0] s;
      assign c = coord_flat[i*W +: W];
      assign s = size_flat[i*W +: W];
      assign lane_ok[i] = (32'(i) >= 32'(used)) || (c < s);
    end
  endgenerate

  assign in_bounds = &lane_ok;

  always_comb begin
    if (!$isunknown(coord_flat) && !$isunknown(size_flat) && in_bounds) begin
      // R9
      bounds_x_chk: assert (coord_flat[W-1:0] < size_flat[W-1:0])
        else $error("x accepted outside surface");
    end
  end
endmodule

// File: rtl/addr_swizzle.sv
module addr_swizzle #(
  parameter int W     = 32,
  parameter int SWZ_W = 8
) (
  input  logic [W-1:0]     off,
  input  logic [SWZ_W-1:0] sh_a,
  input  logic [SWZ_W-1:0] sh_b,
  output logic             flip
);
  localparam int SAT    = 31;
  localparam int TAP    = 6;

  function automatic logic tap_bit(input logic [W-1:0] v, input logic [SWZ_W-1:0] s);
    logic [W-1:0] t;
    if (s >= SWZ_W'(SAT)) return 1'b0;
    t = v >> s;
    return t[TAP];
  endfunction

  logic bit_a;
  logic bit_b;

  assign bit_a = tap_bit(off, sh_a);
  assign bit_b = tap_bit(off, sh_b);
  assign flip  = bit_a ^ bit_b;

  always_comb begin
    if (!$isunknown(sh_a) && !$isunknown(sh_b) &&
        sh_a >= SWZ_W'(SAT) && sh_b >= SWZ_W'(SAT)) begin
      // R8
      swz_sat_chk: assert (!flip) else $error("saturated shifts produced a swizzle");
    end
  end
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen #(
  parameter int ADDR_W = tsa_pkg::WORD_W,
  parameter int TSH_W  = 5,
  parameter int SWZ_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        dims,
  input  logic              tiled,
  input  logic [ADDR_W-1:0] coord_x,
  input  logic [ADDR_W-1:0] coord_y,
  input  logic [ADDR_W-1:0] coord_z,
  input  logic [ADDR_W-1:0] base_x,
  input  logic [ADDR_W-1:0] base_y,
  input  logic [ADDR_W-1:0] size_x,
  input  logic [ADDR_W-1:0] size_y,
  input  logic [ADDR_W-1:0] size_z,
  input  logic [TSH_W-1:0]  tile_lx,
  input  logic [TSH_W-1:0]  tile_ly,
  input  logic [TSH_W-1:0]  tile_lz,
  input  logic [ADDR_W-1:0] bytes_pp,
  input  logic [ADDR_W-1:0] row_pitch,
  input  logic [ADDR_W-1:0] slice_dx,
  input  logic [ADDR_W-1:0] slice_dy,
  input  logic [SWZ_W-1:0]  swz_sa,
  input  logic [SWZ_W-1:0]  swz_sb,
  output logic              done,
  output logic [ADDR_W-1:0] byte_off,
  output logic              in_bounds
);
  import tsa_pkg::*;

  localparam int LANES     = 3;
  localparam int SWZ_TAP   = 6;
  localparam int LAT_EDGES = 7;
  localparam int LAT_W     = $clog2(LAT_EDGES + 1);
  localparam logic [ADDR_W-1:0] ONES = '1;

  seq_state_t        state_q;
  logic [ADDR_W-1:0] ax_q, ay_q, zmin_q, zmaj_q;
  logic [ADDR_W-1:0] idx_q, row_q, acc_q;
  logic              ib_q;
  logic [LAT_W-1:0]  lat_q;

  logic              accept;
  logic [ADDR_W-1:0] z_mask, ay_init;
  logic              ib_now;
  logic [ADDR_W-1:0] mul_a, mul_b, mul_p;
  logic [ADDR_W-1:0] mnx, mjx, mny, mjy, t_idx, t_row;
  logic              swz_flip;

  assign accept  = start && (state_q == ST_IDLE);
  assign z_mask  = ~(ONES << tile_lz);
  assign ay_init = base_y + ((dims >= 2'd2) ? coord_y : '0);

  addr_bounds #(.W(ADDR_W), .LANES(LANES)) u_bounds (
    .coord_flat ({coord_z, coord_y, coord_x}),
    .size_flat  ({size_z, size_y, size_x}),
    .dims       (dims),
    .in_bounds  (ib_now)
  );

  // one multiplier, operands chosen by the step being run
  always_comb begin
    unique case (state_q)
      ST_ZMIN: begin mul_a = zmin_q; mul_b = slice_dx;  end
      ST_ZMAJ: begin mul_a = zmaj_q; mul_b = slice_dy;  end
      ST_ROW:  begin mul_a = row_q;  mul_b = row_pitch; end
      ST_BPP:  begin mul_a = acc_q;  mul_b = bytes_pp;  end
      default: begin mul_a = '0;     mul_b = '0;        end
    endcase
  end

  addr_mul #(.W(ADDR_W)) u_mul (
    .op_a (mul_a),
    .op_b (mul_b),
    .prod (mul_p)
  );

  // tile decomposition: a Y tile is a column of narrow sub-tiles
  assign mnx   = ax_q & ~(ONES << tile_lx);
  assign mjx   = ax_q >> tile_lx;
  assign mny   = ay_q & ~(ONES << tile_ly);
  assign mjy   = ay_q >> tile_ly;
  assign t_idx = (((mjx << tile_ly) + mny) << tile_lx) + mnx;
  assign t_row = mjy << tile_ly;

  addr_swizzle #(.W(ADDR_W), .SWZ_W(SWZ_W)) u_swz (
    .off  (acc_q),
    .sh_a (swz_sa),
    .sh_b (swz_sb),
    .flip (swz_flip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ax_q      <= '0;
      ay_q      <= '0;
      zmin_q    <= '0;
      zmaj_q    <= '0;
      idx_q     <= '0;
      row_q     <= '0;
      acc_q     <= '0;
      ib_q      <= 1'b0;
      lat_q     <= '0;
      done      <= 1'b0;
      byte_off  <= '0;
      in_bounds <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept)
        lat_q <= LAT_W'(1);
      else if (state_q != ST_IDLE)
        lat_q <= lat_q + LAT_W'(1);

      unique case (state_q)
        ST_IDLE: if (start) begin
          ax_q    <= base_x + coord_x;
          ay_q    <= ay_init;
          zmin_q  <= (dims == 2'd3) ? (coord_z & z_mask) : '0;
          zmaj_q  <= (dims == 2'd3) ? (coord_z >> tile_lz) : '0;
          ib_q    <= ib_now;
          state_q <= ST_ZMIN;
        end
        ST_ZMIN: begin
          ax_q    <= ax_q + mul_p;
          state_q <= ST_ZMAJ;
        end
        ST_ZMAJ: begin
          ay_q    <= ay_q + mul_p;
          state_q <= ST_TILE;
        end
        ST_TILE: begin
          idx_q   <= tiled ? t_idx : ax_q;
          row_q   <= tiled ? t_row : ay_q;
          state_q <= ST_ROW;
        end
        ST_ROW: begin
          acc_q   <= idx_q + mul_p;
          state_q <= ST_BPP;
        end
        ST_BPP: begin
          acc_q   <= mul_p;
          state_q <= ST_SWZ;
        end
        ST_SWZ: begin
          byte_off  <= acc_q ^ (ADDR_W'(tiled & swz_flip) << SWZ_TAP);
          in_bounds <= ib_q;
          done      <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == LAT_W'(LAT_EDGES)))
    else $error("result strobe at wrong latency");

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("result strobe longer than one cycle");

  // R2
  offset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(byte_off) && $stable(in_bounds)))
    else $error("result changed without strobe");

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (start && state_q != ST_IDLE) |=> (lat_q != LAT_W'(1)))
    else $error("start accepted while busy");
endmodule

// File: tb/tb_tiled_addr_gen.sv
module tb_tiled_addr_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, start, tiled;
  logic [1:0]  dims;
  logic [31:0] cx, cy, cz, bx, by, szx, szy, szz, bpp, pitch, sdx, sdy;
  logic [4:0]  tlx, tly, tlz;
  logic [7:0]  sa, sb;
  logic        done, ib;
  logic [31:0] off;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  tiled_addr_gen dut (
    .clk(clk), .rst(rst), .start(start), .dims(dims), .tiled(tiled),
    .coord_x(cx), .coord_y(cy), .coord_z(cz), .base_x(bx), .base_y(by),
    .size_x(szx), .size_y(szy), .size_z(szz),
    .tile_lx(tlx), .tile_ly(tly), .tile_lz(tlz),
    .bytes_pp(bpp), .row_pitch(pitch), .slice_dx(sdx), .slice_dy(sdy),
    .swz_sa(sa), .swz_sb(sb),
    .done(done), .byte_off(off), .in_bounds(ib)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic sbit(input logic [31:0] v, input logic [7:0] s);
    if (s >= 8'd31) return 1'b0;
    return v[s + 6];
  endfunction

  function automatic logic [31:0] ref_off();
    logic [31:0] ax, ay, p, q, idx, row, o;
    ax = bx + cx;
    ay = by + ((dims >= 2) ? cy : 32'd0);
    if (dims == 2'd3) begin
      p  = 32'd1 << tlz;
      ax = ax + (cz % p) * sdx;
      ay = ay + (cz / p) * sdy;
    end
    if (tiled) begin
      p   = 32'd1 << tlx;
      q   = 32'd1 << tly;
      idx = ((ax / p) * q + (ay % q)) * p + (ax % p);
      row = (ay / q) * q;
    end else begin
      idx = ax;
      row = ay;
    end
    o = (idx + row * pitch) * bpp;
    if (tiled && (sbit(o, sa) ^ sbit(o, sb))) o = o ^ 32'h40;
    return o;
  endfunction

  function automatic logic ref_ib();
    logic ok;
    ok = cx < szx;
    if (dims >= 2) ok = ok && (cy < szy);
    if (dims == 3) ok = ok && (cz < szz);
    return ok;
  endfunction

  // runs one request; checks strobe timing (R2) and results
  task automatic run_op(input string tag);
    logic [31:0] eo;
    logic        eb;
    eo = ref_off();
    eb = ref_ib();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 done early", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R2 done", {31'd0, done}, 32'd1);
    chk(tag, off, eo);
    chk("R9 in_bounds", {31'd0, ib}, {31'd0, eb});
    @(negedge clk);
    chk("R2 pulse", {31'd0, done}, 32'd0);
    chk("R2 hold", off, eo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    rst = 1'b1; start = 1'b0; tiled = 1'b0; dims = 2'd1;
    cx = 0; cy = 0; cz = 0; bx = 3; by = 2;
    szx = 8; szy = 5; szz = 3; bpp = 4; pitch = 40; sdx = 8; sdy = 6;
    tlx = 0; tly = 0; tlz = 1; sa = 8'hFF; sb = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 off", off, 32'd0);
    chk("R1 ib", {31'd0, ib}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {30'd0, done, ib} | off, 32'd0);

    // sweep: linear, X-like, Y-like, tiled without swizzle
    for (int cfg = 0; cfg < 4; cfg++) begin
      case (cfg)
        0: begin tiled = 1'b0; tlx = 0; tly = 0; sa = 8'hFF; sb = 8'hFF; end
        1: begin tiled = 1'b1; tlx = 3; tly = 2; sa = 8'd3;  sb = 8'd4;  end
        2: begin tiled = 1'b1; tlx = 1; tly = 3; sa = 8'd3;  sb = 8'hFF; end
        default: begin tiled = 1'b1; tlx = 2; tly = 1; sa = 8'hFF; sb = 8'd40; end
      endcase
      for (int d = 0; d < 4; d++)
        for (int x = 0; x < 10; x++)
          for (int y = 0; y < 6; y++)
            for (int z = 0; z < 4; z++) begin
              dims = 2'(d); cx = 32'(x); cy = 32'(y); cz = 32'(z);
              run_op(cfg == 0 ? "R6/R4/R5 linear" :
                     cfg == 3 ? "R7/R4/R5 tiled" : "R8/R7 swizzled");
            end
    end

    // R8 directed: bit 9 folded into bit 6
    tiled = 1'b1; dims = 2'd1; tlx = 0; tly = 0; bx = 0; by = 0;
    pitch = 0; bpp = 1; cx = 32'h200; sa = 8'd3; sb = 8'hFF;
    run_op("R8 one shift");
    chk("R8 value", off, 32'h240);
    sa = 8'd31; sb = 8'hFF;
    run_op("R8 both saturated");
    chk("R8 disabled", off, 32'h200);
    sa = 8'd3; sb = 8'd3;
    run_op("R8 equal shifts cancel");
    chk("R8 cancel", off, 32'h200);

    // R10 wraparound
    tiled = 1'b0; dims = 2'd2; bx = 32'hFFFF_FFF0; cx = 32'h20; by = 0; cy = 1;
    pitch = 32'h8000_0000; bpp = 2; szx = 32'hFFFF_FFFF; szy = 2;
    run_op("R10 wrap");
    chk("R10 value", off, 32'h20);

    // R11 tile shifts of 31
    tiled = 1'b1; dims = 2'd3; tlx = 31; tly = 31; tlz = 31;
    bx = 0; by = 0; cx = 32'h8000_0005; cy = 7; cz = 32'h8000_0001;
    sdx = 1; sdy = 1; pitch = 3; bpp = 1; sa = 8'hFF; sb = 8'hFF; szz = 32'hFFFF_FFFF;
    run_op("R11 max shifts");

    // R9 unsigned compare: all-ones coordinate is outside
    tiled = 1'b0; tlx = 0; tly = 0; tlz = 1; dims = 2'd2;
    cx = 0; cy = 32'hFFFF_FFFF; szx = 8; szy = 5; pitch = 40; bpp = 4;
    run_op("R9 unsigned");
    chk("R9 outside", {31'd0, ib}, 32'd0);

    // R3 start while busy is ignored
    dims = 2'd1; cx = 2; by = 2; bx = 3;
    keep = ref_off();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk) begin start = 1'b1; cx = 7; end
    @(negedge clk) start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 done", {31'd0, done}, 32'd1);
    chk("R3 first result", off, keep);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R3 no extra done", {31'd0, done}, 32'd0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule